// File: doc/BRIEF.md
# Event-Triggered Capture Bank with Split or Unified Width

This block holds a bank of capture registers that snapshot a timer value when selected event strobes fire. The timer runs either as one 32-bit counter, or as two independent 16-bit counters (a low counter and a high counter). The `unify` input picks between the two modes.

Each capture slot has its own control word with two event-select fields, one for each half:
- In split mode, the low half of a slot loads from the low counter on its low-field events. The high half loads from the high counter on its high-field events.
- In unified mode, only the low field matters. A selected event loads all 32 bits from `{cnt_hi, cnt_lo}`.

Software reaches control words and capture registers through a simple register port:
- Writes can cover the low 16 bits, the high 16 bits, or both.
- The port has no valid/ready handshake and no back-pressure. A write takes effect at the clock edge where `reg_wr` is high, and it can never stall.
- Reads are combinational from `reg_addr`.

Event strobes are sampled at each rising clock edge. A capture takes the counter value present at that edge and shows on `cap_out` and on the read port right after it.

Top module: `evcap_bank`

## Requirements
- R1: After reset, every control word and every capture register reads zero.
- R2: In split mode (`unify`=0), if control bit m (bits 7:0) is one and event m is high at an edge, capture bits 15:0 take `cnt_lo` from that edge. Capture bits 31:16 stay unchanged unless their own field selects a firing event.
- R3: In split mode, if control bit 16+m is one and event m is high at an edge, capture bits 31:16 take `cnt_hi` from that edge.
- R4: In unified mode (`unify`=1), if low-field bit m is one and event m fires, all 32 capture bits take `{cnt_hi, cnt_lo}`. The high field (bits 23:16) has no effect in this mode.
- R5: When no firing event is selected and no write targets the slot, the capture register holds its value.
- R6: If several selected events fire in one cycle, the register captures once, with that cycle's counter value.
- R7: `reg_half` bit 0 enables a write to bits 15:0 and bit 1 enables bits 31:16. Both set makes a 32-bit write. Each half of a control word can be written on its own.
- R8: Control bits 15:8 and 31:24 always read zero, and writes to them are dropped.
- R9: Software can write either half of a capture register. If a capture hits the same half in the same cycle, the captured value wins.
- R10: `reg_addr` bit 3 selects the space (0 = control word, 1 = capture register), and bits 2:0 select the slot. `reg_rdata` shows the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unify | input | 1 | 1 = one 32-bit counter, 0 = two 16-bit counters |
| cnt_lo | input | 16 | Low counter value (low half of the unified counter) |
| cnt_hi | input | 16 | High counter value (high half of the unified counter) |
| evt | input | 8 | Event strobes, bit m = event m |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Bit 3 space select, bits 2:0 slot |
| reg_half | input | 2 | Write enables for bits 15:0 (bit 0) and 31:16 (bit 1) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cap_out | output | 256 | All capture registers, slot k at bits 32k+31:32k |

## Verification
The bench builds the bank with its default parameters: eight slots, eight events and 16-bit halves. At this size, every pairing of slot and event can be swept in each of four configurations: split-low, split-high, unified-low and unified with only the high field set. Each pairing is also checked against every other event firing together, which must leave the slot untouched. Directed cases then cover simultaneous events, half writes to control words, reserved-bit masking, and a software write colliding with a capture.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  // Register space selected by the top address bit
  typedef enum logic {
    SPC_CTRL = 1'b0,
    SPC_CAP  = 1'b1
  } reg_space_e;
endpackage

// File: rtl/evcap_ctrl.sv
// Per-slot control word: two event-select fields, each half writable alone.
module evcap_ctrl #(
  parameter int N_EVT  = 8,
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int PAD_W  = HALF_W - N_EVT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [N_EVT-1:0]  sel_lo,
  output logic [N_EVT-1:0]  sel_hi,
  output logic [WORD_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_lo <= '0;
      sel_hi <= '0;
    end else begin
      if (wr_lo) sel_lo <= wdata[N_EVT-1:0];
      if (wr_hi) sel_hi <= wdata[HALF_W +: N_EVT];
    end
  end

  assign rdata = {{PAD_W{1'b0}}, sel_hi, {PAD_W{1'b0}}, sel_lo};

  AST_CTRL_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(sel_hi)); // R7
  AST_CTRL_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> $stable(sel_lo)); // R7

endmodule

// File: rtl/evcap_slot.sv
// One capture register built from two halves that load independently.
module evcap_slot #(
  parameter int N_EVT  = 8,
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unify,
  input  logic [HALF_W-1:0] cnt_lo,
  input  logic [HALF_W-1:0] cnt_hi,
  input  logic [N_EVT-1:0]  evt,
  input  logic [N_EVT-1:0]  sel_lo,
  input  logic [N_EVT-1:0]  sel_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cap
);

  logic              hit_lo, hit_hi;
  logic [HALF_W-1:0] cap_lo, cap_hi;

  // Any number of matching events collapse into one load
  assign hit_lo = |(evt & sel_lo);
  assign hit_hi = unify ? hit_lo : |(evt & sel_hi);

  // Capture takes priority over a software write to the same half
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_lo <= '0;
      cap_hi <= '0;
    end else begin
      if (hit_lo)     cap_lo <= cnt_lo;
      else if (wr_lo) cap_lo <= wdata[HALF_W-1:0];
      if (hit_hi)     cap_hi <= cnt_hi;
      else if (wr_hi) cap_hi <= wdata[WORD_W-1:HALF_W];
    end
  end

  assign cap = {cap_hi, cap_lo};

  AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & sel_lo)) |=> cap[HALF_W-1:0] == $past(cnt_lo)); // R2
  AST_HI_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!unify && |(evt & sel_hi)) |=> cap[WORD_W-1:HALF_W] == $past(cnt_hi)); // R3
  AST_UNI_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (unify && |(evt & sel_lo)) |=> cap == $past({cnt_hi, cnt_lo})); // R4
  AST_UNI_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (unify && !(|(evt & sel_lo)) && !wr_hi) |=> $stable(cap[WORD_W-1:HALF_W])); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(evt & sel_lo)) && !(|(evt & sel_hi)) && !wr_lo && !wr_hi) |=> $stable(cap)); // R5
  AST_WRITE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !(|(evt & sel_lo))) |=> cap[HALF_W-1:0] == $past(wdata[HALF_W-1:0])); // R9

endmodule

// File: rtl/evcap_bank.sv
// Bank of capture slots with a shared register port.
module evcap_bank
  import evcap_pkg::*;
#(
  parameter int N_SLOT = 8,
  parameter int N_EVT  = 8,
  parameter int HALF_W = 16,
  localparam int WORD_W  = 2 * HALF_W,
  localparam int SLOT_AW = $clog2(N_SLOT),
  localparam int ADDR_W  = SLOT_AW + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     unify,
  input  logic [HALF_W-1:0]        cnt_lo,
  input  logic [HALF_W-1:0]        cnt_hi,
  input  logic [N_EVT-1:0]         evt,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [1:0]               reg_half,
  input  logic [WORD_W-1:0]        reg_wdata,
  output logic [WORD_W-1:0]        reg_rdata,
  output logic [N_SLOT*WORD_W-1:0] cap_out
);

  reg_space_e         space;
  logic [SLOT_AW-1:0] idx;
  logic [WORD_W-1:0]  ctrl_rd [N_SLOT];
  logic [WORD_W-1:0]  cap_rd  [N_SLOT];

  assign space = reg_space_e'(reg_addr[SLOT_AW]);
  assign idx   = reg_addr[SLOT_AW-1:0];

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic             hit_slot;
    logic             cw_lo, cw_hi, kw_lo, kw_hi;
    logic [N_EVT-1:0] s_lo, s_hi;

    assign hit_slot = reg_wr && (idx == SLOT_AW'(g));
    assign cw_lo = hit_slot && (space == SPC_CTRL) && reg_half[0];
    assign cw_hi = hit_slot && (space == SPC_CTRL) && reg_half[1];
    assign kw_lo = hit_slot && (space == SPC_CAP)  && reg_half[0];
    assign kw_hi = hit_slot && (space == SPC_CAP)  && reg_half[1];

    evcap_ctrl #(.N_EVT(N_EVT), .HALF_W(HALF_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (cw_lo),
      .wr_hi  (cw_hi),
      .wdata  (reg_wdata),
      .sel_lo (s_lo),
      .sel_hi (s_hi),
      .rdata  (ctrl_rd[g])
    );

    evcap_slot #(.N_EVT(N_EVT), .HALF_W(HALF_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .unify  (unify),
      .cnt_lo (cnt_lo),
      .cnt_hi (cnt_hi),
      .evt    (evt),
      .sel_lo (s_lo),
      .sel_hi (s_hi),
      .wr_lo  (kw_lo),
      .wr_hi  (kw_hi),
      .wdata  (reg_wdata),
      .cap    (cap_rd[g])
    );

    assign cap_out[g*WORD_W +: WORD_W] = cap_rd[g];
  end

  always_comb begin
    reg_rdata = '0;
    if (int'(idx) < N_SLOT) begin
      reg_rdata = (space == SPC_CAP) ? cap_rd[idx] : ctrl_rd[idx];
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (space == SPC_CTRL) |->
      (reg_rdata[HALF_W-1:N_EVT] == '0 && reg_rdata[WORD_W-1:HALF_W+N_EVT] == '0)); // R8

endmodule

// File: tb/sim_evcap_bank.sv
module sim_evcap_bank;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         unify;
  logic [15:0]  cnt_lo, cnt_hi;
  logic [7:0]   evt;
  logic         reg_wr;
  logic [3:0]   reg_addr;
  logic [1:0]   reg_half;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [255:0] cap_out;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  evcap_bank u0 (
    .clk(clk), .rst_n(rst_n), .unify(unify), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .evt(evt), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_half(reg_half),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_out(cap_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic spc, input int slot, input logic [1:0] half, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {spc, 3'(slot)}; reg_half = half; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_half = 2'b00;
  endtask

  task automatic rd(input logic spc, input int slot, output logic [31:0] d);
    reg_addr = {spc, 3'(slot)};
    #1 d = reg_rdata;
  endtask

  task automatic fire(input logic [7:0] e, input logic [15:0] lo, input logic [15:0] hi);
    @(negedge clk);
    cnt_lo = lo; cnt_hi = hi; evt = e;
    @(negedge clk);
    evt = '0; cnt_lo = ~lo; cnt_hi = ~hi;
  endtask

  function automatic logic [31:0] cap_of(input int s);
    return cap_out[s*32 +: 32];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; unify = 1'b0; cnt_lo = '0; cnt_hi = '0; evt = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_half = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 both spaces readable
    for (int s = 0; s < 8; s++) begin
      rd(1'b0, s, d); check("R1 ctrl reset", d, 32'h0);
      rd(1'b1, s, d); check("R1 cap reset R10", d, 32'h0);
    end

    // Sweep: mode p x slot x event
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 8; s++) begin
        for (int m = 0; m < 8; m++) begin
          logic [15:0] lo, hi;
          logic [31:0] pre, exp;
          lo  = 16'(p * 4096 + s * 64 + m * 4 + 1);
          hi  = 16'(16'hC000 ^ (s * 256) ^ (m * 8));
          pre = 32'hA5A5_5A5A ^ 32'(s * 17 + m);
          unify = (p >= 2);
          wr(1'b0, s, 2'b11, (p == 0 || p == 2) ? (32'h1 << m) : (32'h1 << (16 + m)));
          wr(1'b1, s, 2'b11, pre);
          // R5: every other event fires, none selected
          fire(~(8'h1 << m), lo, hi);
          check("R5 unselected events hold", cap_of(s), pre);
          fire(8'h1 << m, lo, hi);
          case (p)
            0: exp = {pre[31:16], lo};
            1: exp = {hi, pre[15:0]};
            2: exp = {hi, lo};
            default: exp = pre;
          endcase
          case (p)
            0: check("R2 split low capture", cap_of(s), exp);
            1: check("R3 split high capture", cap_of(s), exp);
            2: check("R4 unified capture", cap_of(s), exp);
            default: check("R4 high field ignored when unified", cap_of(s), exp);
          endcase
          rd(1'b1, s, d); check("R10 capture readback", d, exp);
        end
      end
    end

    // R6: several selected events in one cycle
    unify = 1'b0;
    wr(1'b0, 0, 2'b11, 32'h00F0_000F);
    wr(1'b1, 0, 2'b11, 32'h0);
    fire(8'hFF, 16'h1234, 16'h5678);
    check("R6 multi-event single capture", cap_of(0), 32'h5678_1234);
    fire(8'h05, 16'h4321, 16'h8765);
    check("R6 two low events", cap_of(0), 32'h5678_4321);

    // R7 / R8: half writes and reserved bits
    wr(1'b0, 2, 2'b11, 32'hFFFF_FFFF);
    rd(1'b0, 2, d); check("R8 reserved bits zero", d, 32'h00FF_00FF);
    wr(1'b0, 2, 2'b01, 32'hFFFF_0003);
    rd(1'b0, 2, d); check("R7 low half write", d, 32'h00FF_0003);
    wr(1'b0, 2, 2'b10, 32'h1A12_FFFF);
    rd(1'b0, 2, d); check("R7 high half write R8", d, 32'h0012_0003);
    wr(1'b0, 2, 2'b00, 32'h0000_0000);
    rd(1'b0, 2, d); check("R7 no-half write ignored", d, 32'h0012_0003);

    // R9: capture half writes and collision
    wr(1'b0, 3, 2'b11, 32'h0000_0004);
    wr(1'b1, 3, 2'b11, 32'h0000_0000);
    wr(1'b1, 3, 2'b10, 32'hBEEF_CAFE);
    check("R9 high half write only", cap_of(3), 32'hBEEF_0000);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {1'b1, 3'd3}; reg_half = 2'b11; reg_wdata = 32'h1111_2222;
    cnt_lo = 16'h7777; cnt_hi = 16'h9999; evt = 8'h04;
    @(negedge clk);
    reg_wr = 1'b0; reg_half = 2'b00; evt = '0;
    check("R9 capture beats write", cap_of(3), 32'h1111_7777);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule